// File: doc/BRIEF.md
# Flash Read-Retry Mode Programmer

This block places a multi-level-cell flash device into one of its read-retry modes. When the controller pulses `start` with a mode index, the block emits a short stream of flash-bus items. Each item is a command byte, an address byte or a data byte, and each is passed with a valid/ready handshake. The stream opens with a vendor command that enters parameter-set mode. For each register in a configurable list of register offsets, it then writes one address byte carrying the offset and one data byte carrying the value for that mode and register. It closes with a vendor command that applies the new settings.

The register offsets and the value table sit in small storage that the host loads through a simple write port. The values are kept as one flattened array, with all register values for a mode placed next to each other. At the end of a sequence the block gives a single-cycle `done` pulse, with `err` raised in the same cycle if the sequence failed. A sequence fails when the mode index is out of range, when the bus reports an error, or when the handshake stalls for too long.

Top module: `rr_retry_prog`

## Requirements
- R1: After reset, `busy`, `bus_valid`, `done` and `err` are all 0.
- R2: An accepted sequence begins with a command item (`bus_kind` 0) carrying byte 0x36.
- R3: For each register position i from 0 to NREGS-1 in turn, the block sends one address item (`bus_kind` 1) carrying offset[i], followed by one data item (`bus_kind` 2) carrying the value at flat table index mode*NREGS+i.
- R4: Out of reset, the offset list holds 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF for positions 0 to 7.
- R5: While an address item is valid, `bus_col` carries the offset byte in both its upper and lower byte.
- R6: After the data item of the last register, the block sends command 0x16. In the cycle after that handshake, `done` is 1 and `err` is 0. `done` is high for exactly one cycle.
- R7: If `bus_err` is high while `bus_valid` is high, the sequence stops. No further item is sent, and in the next cycle `done` and `err` are both 1.
- R8: If `bus_ready` stays low for TIMEOUT consecutive cycles while an item is valid, the sequence stops without sending the apply command, and `done` and `err` are both 1.
- R9: A start with a mode index of NMODES or above produces `done` and `err` in the next cycle and no bus item.
- R10: `start` has no effect while `busy` is 1. A sequence produces exactly one `done` pulse and is not followed by a second sequence.
- R11: While `bus_valid` is 1 and `bus_ready` is 0, the item on `bus_kind` and `bus_byte` does not change unless the sequence is aborted.
- R12: A host write with `cfg_sel` 1 replaces offset[`cfg_addr`]. A host write with `cfg_sel` 0 replaces table entry `cfg_addr`. Later sequences use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence for `mode` |
| mode | input | MW | Requested read-retry mode index |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 1 | Write target: 1 offset list, 0 value table |
| cfg_addr | input | AW | Host write position |
| cfg_wdata | input | 8 | Host write byte |
| bus_valid | output | 1 | A bus item is offered |
| bus_ready | input | 1 | The bus accepts the item |
| bus_err | input | 1 | The bus reports a failure |
| bus_kind | output | 2 | 0 command, 1 address, 2 data |
| bus_byte | output | 8 | Item byte |
| bus_col | output | 16 | Column word for address items |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Failure flag, valid with `done` |

## Verification
A wrong register position or mode latch would show at the ports as a bad address or data byte at the very handshake where it occurs, so the scoreboard flags it at once. A state machine stuck in a waiting state would hold `bus_valid` and never produce `done`, and the bench catches this within its per-sequence cycle bound. An abort that fails to stop the sequence would let an item through after the error, or would send the apply command, and the scoreboard treats that item as unexpected on the next handshake.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_DATA = 2'd2
  } bus_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ENTER,
    S_ADDR,
    S_DATA,
    S_APPLY
  } seq_state_e;

  localparam logic [7:0] CMD_ENTER = 8'h36;
  localparam logic [7:0] CMD_APPLY = 8'h16;

  function automatic logic [7:0] default_offset(input int pos);
    case (pos)
      0:       return 8'hCC;
      1:       return 8'hBF;
      2:       return 8'hAA;
      3:       return 8'hAB;
      4:       return 8'hCD;
      5:       return 8'hAD;
      6:       return 8'hAE;
      7:       return 8'hAF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rr_table.sv
module rr_table #(
  parameter int NREGS  = 8,
  parameter int NMODES = 8,
  parameter int MW     = 4,
  parameter int IW     = 3,
  parameter int AW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  input  logic [MW-1:0] rd_mode,
  output logic [7:0]    off_out,
  output logic [7:0]    val_out
);
  localparam int DEPTH = NREGS * NMODES;

  logic [7:0]    off_q [NREGS];
  logic [7:0]    mem   [DEPTH];
  logic [AW-1:0] flat;

  // offset list: one register per position, reset to the default list
  for (genvar g = 0; g < NREGS; g++) begin : g_off
    logic off_ld;
    assign off_ld = wr_en && wr_sel && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q[g] <= rr_pkg::default_offset(g);
      end else if (off_ld) begin
        off_q[g] <= wr_data;
      end
    end
  end

  // value table storage, no reset
  always_ff @(posedge clk) begin
    if (wr_en && !wr_sel) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    flat    = AW'(rd_mode) * AW'(NREGS) + AW'(rd_idx);
    off_out = off_q[rd_idx];
    val_out = mem[flat];
  end
endmodule

// File: rtl/rr_timer.sv
module rr_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n   = run ? cnt_q + CW'(1) : '0;
    expired = run && (cnt_q == CW'(LIMIT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/rr_seq.sv
module rr_seq
  import rr_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int NMODES = 8,
  parameter int MW     = 4,
  parameter int IW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] mode,
  input  logic          bus_ready,
  input  logic          bus_err,
  input  logic          expired,
  input  logic [7:0]    off,
  input  logic [7:0]    val,
  output logic          bus_valid,
  output logic [1:0]    bus_kind,
  output logic [7:0]    bus_byte,
  output logic [15:0]   bus_col,
  output logic [IW-1:0] rd_idx,
  output logic [MW-1:0] rd_mode,
  output logic          timer_run,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam logic [IW-1:0] LAST = IW'(NREGS - 1);

  seq_state_e    state_q, state_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [MW-1:0] mode_q;
  logic          mode_ld;
  logic          done_q, done_n;
  logic          err_q, err_n;
  logic          hs, abort;

  // bus item decode
  always_comb begin
    bus_valid = (state_q != S_IDLE);
    bus_kind  = BK_CMD;
    bus_byte  = 8'h00;
    bus_col   = 16'h0000;
    case (state_q)
      S_ENTER: bus_byte = CMD_ENTER;
      S_ADDR: begin
        bus_kind = BK_ADDR;
        bus_byte = off;
        bus_col  = {off, off};
      end
      S_DATA: begin
        bus_kind = BK_DATA;
        bus_byte = val;
      end
      S_APPLY: bus_byte = CMD_APPLY;
      default: ;
    endcase
    hs        = bus_valid && bus_ready && !bus_err;
    abort     = bus_valid && (bus_err || expired);
    timer_run = bus_valid && !bus_ready;
  end

  // next state
  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    mode_ld = 1'b0;
    done_n  = 1'b0;
    err_n   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          if (32'(mode) < 32'(NMODES)) begin
            state_n = S_ENTER;
            idx_n   = '0;
            mode_ld = 1'b1;
          end else begin
            done_n = 1'b1;
            err_n  = 1'b1;
          end
        end
      end
      S_ENTER: if (hs) state_n = S_ADDR;
      S_ADDR:  if (hs) state_n = S_DATA;
      S_DATA: begin
        if (hs) begin
          if (idx_q == LAST) begin
            state_n = S_APPLY;
          end else begin
            state_n = S_ADDR;
            idx_n   = idx_q + IW'(1);
          end
        end
      end
      S_APPLY: begin
        if (hs) begin
          state_n = S_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = S_IDLE;
    endcase
    if (abort) begin
      state_n = S_IDLE;
      done_n  = 1'b1;
      err_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_ld) begin
      mode_q <= mode;
    end
  end

  assign rd_idx  = idx_q;
  assign rd_mode = mode_q;
  assign busy    = (state_q != S_IDLE);
  assign done    = done_q;
  assign err     = err_q;
endmodule

// File: rtl/rr_retry_prog.sv
module rr_retry_prog #(
  parameter int NREGS   = 8,
  parameter int NMODES  = 8,
  parameter int MW      = 4,
  parameter int TIMEOUT = 16,
  parameter int AW      = $clog2(NREGS * NMODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] mode,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  input  logic          bus_err,
  output logic [1:0]    bus_kind,
  output logic [7:0]    bus_byte,
  output logic [15:0]   bus_col,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic          rst_m_q, rst_s_q;
  logic [IW-1:0] rd_idx;
  logic [MW-1:0] rd_mode;
  logic [7:0]    off, val;
  logic          timer_run, expired;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  rr_table #(
    .NREGS(NREGS), .NMODES(NMODES), .MW(MW), .IW(IW), .AW(AW)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .rd_idx  (rd_idx),
    .rd_mode (rd_mode),
    .off_out (off),
    .val_out (val)
  );

  rr_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .run     (timer_run),
    .expired (expired)
  );

  rr_seq #(
    .NREGS(NREGS), .NMODES(NMODES), .MW(MW), .IW(IW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .start     (start),
    .mode      (mode),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .expired   (expired),
    .off       (off),
    .val       (val),
    .bus_valid (bus_valid),
    .bus_kind  (bus_kind),
    .bus_byte  (bus_byte),
    .bus_col   (bus_col),
    .rd_idx    (rd_idx),
    .rd_mode   (rd_mode),
    .timer_run (timer_run),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );
endmodule

// File: rtl/rr_prog_chk.sv
module rr_prog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       bus_ready,
  input logic       bus_err,
  input logic [1:0] bus_kind,
  input logic [7:0] bus_byte,
  input logic       busy,
  input logic       done,
  input logic       err
);
  assert_enter_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> (bus_kind == 2'd0 && bus_byte == 8'h36));

  assert_addr_then_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_err && bus_kind == 2'd1) |=> (bus_valid && bus_kind == 2'd2));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_err) |=> (!bus_valid && done && err));

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid);

  assert_hold_item_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready && !bus_err) |=>
      ((bus_valid && $stable(bus_kind) && $stable(bus_byte)) || (done && err)));
endmodule

bind rr_retry_prog rr_prog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_err   (bus_err),
  .bus_kind  (bus_kind),
  .bus_byte  (bus_byte),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/rr_retry_prog_test.sv
module rr_retry_prog_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS   = 8;
  localparam int NMODES  = 8;
  localparam int MW      = 4;
  localparam int TIMEOUT = 16;
  localparam int AW      = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] mode = '0;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic          bus_valid;
  logic          bus_ready = 1'b1;
  logic          bus_err = 1'b0;
  logic [1:0]    bus_kind;
  logic [7:0]    bus_byte;
  logic [15:0]   bus_col;
  logic          busy, done, err;

  int checks = 0;
  int errors = 0;
  int hs_cnt = 0;
  int cyc = 0;
  int act = 0;      // 0 none, 1 bus error, 2 stall forever
  int act_at = 0;
  int stall_pat = 0;

  logic [9:0] exp_q[$];
  logic [7:0] m_off [NREGS];
  logic [7:0] m_val [NREGS*NMODES];

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_retry_prog #(.NREGS(NREGS), .NMODES(NMODES), .MW(MW), .TIMEOUT(TIMEOUT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_err(bus_err),
    .bus_kind(bus_kind), .bus_byte(bus_byte), .bus_col(bus_col),
    .busy(busy), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  // bus responder: drives ready and error just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (act == 1 && hs_cnt == act_at && bus_valid) begin
      bus_err   = 1'b1;
      bus_ready = 1'b0;
    end else if (act == 2 && hs_cnt >= act_at) begin
      bus_err   = 1'b0;
      bus_ready = 1'b0;
    end else begin
      bus_err   = 1'b0;
      bus_ready = (stall_pat == 0) ? 1'b1 : (cyc % 3 != 0);
    end
  end

  // monitor: compares each accepted item with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && bus_valid && bus_ready && !bus_err) begin
      hs_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected bus item", int'({bus_kind, bus_byte}), 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check({bus_kind, bus_byte} == e, "R3 bus item", int'({bus_kind, bus_byte}), int'(e));
        if (bus_kind == 2'd1)
          check(bus_col == {bus_byte, bus_byte}, "R5 column word", int'(bus_col), int'({bus_byte, bus_byte}));
      end
    end
  end

  task automatic cfg_write(input bit sel, input int addr, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = AW'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_off[addr] = data; else m_val[addr] = data;
  endtask

  // driver: pushes expected items, starts, waits for the end
  task automatic run_seq(input int m, input int a, input int a_at, input bit exp_err,
                         input bit extra_start, input string req);
    logic [9:0] full[$];
    int limit;
    int waited;
    full.push_back({2'd0, 8'h36});
    for (int i = 0; i < NREGS; i++) begin
      full.push_back({2'd1, m_off[i]});
      if (m < NMODES) full.push_back({2'd2, m_val[m*NREGS + i]});
    end
    full.push_back({2'd0, 8'h16});
    limit = (m >= NMODES) ? 0 : ((a != 0) ? a_at : full.size());
    for (int i = 0; i < limit; i++) exp_q.push_back(full[i]);
    hs_cnt = 0; act = a; act_at = a_at;
    @(negedge clk);
    start = 1'b1; mode = MW'(m);
    @(negedge clk);
    start = 1'b0; mode = '0;
    waited = 1;
    if (extra_start) begin
      check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waited++;
    end
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, {req, " done seen"}, int'(done), 1);
    check(err == exp_err, {req, " err flag"}, int'(err), int'(exp_err));
    check(exp_q.size() == 0, {req, " all items sent"}, exp_q.size(), 0);
    if (a == 2) check(waited >= TIMEOUT, "R8 timeout not early", waited, TIMEOUT);
    act = 0;
    exp_q.delete();
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", int'(done), 0);
    for (int k = 0; k < 3; k++) begin
      check(!busy && !bus_valid, "R10 no further sequence", int'({busy, bus_valid}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) m_off[i] = 8'h00;
    m_off[0] = 8'hCC; m_off[1] = 8'hBF; m_off[2] = 8'hAA; m_off[3] = 8'hAB;
    m_off[4] = 8'hCD; m_off[5] = 8'hAD; m_off[6] = 8'hAE; m_off[7] = 8'hAF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !bus_valid && !done && !err, "R1 reset state",
          int'({busy, bus_valid, done, err}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !bus_valid && !done && !err, "R1 after release",
          int'({busy, bus_valid, done, err}), 0);
    // R12 load value table
    for (int i = 0; i < NREGS*NMODES; i++) cfg_write(1'b0, i, 8'((i * 37 + 5) & 8'hFF));
    // R2 R3 R4 R6 default offsets, mode 0 and mode 5
    run_seq(0, 0, 0, 1'b0, 1'b0, "R4 default offsets mode 0");
    run_seq(5, 0, 0, 1'b0, 1'b0, "R6 apply mode 5");
    // R11 handshake stalls
    stall_pat = 1;
    run_seq(NMODES - 1, 0, 0, 1'b0, 1'b0, "R11 stalled mode 7");
    stall_pat = 0;
    // R9 out-of-range modes
    run_seq(NMODES, 0, 0, 1'b1, 1'b0, "R9 mode at limit");
    run_seq(15, 0, 0, 1'b1, 1'b0, "R9 mode 15");
    // R7 bus error in the middle and on the enter command
    run_seq(2, 1, 5, 1'b1, 1'b0, "R7 error mid");
    run_seq(3, 1, 0, 1'b1, 1'b0, "R7 error first");
    // R8 timeout after a few items and before apply
    run_seq(4, 2, 3, 1'b1, 1'b0, "R8 timeout mid");
    run_seq(1, 2, 17, 1'b1, 1'b0, "R8 timeout before apply");
    // R10 second start while busy
    run_seq(6, 0, 0, 1'b0, 1'b1, "R10 start while busy");
    // R12 reload offsets and a value
    cfg_write(1'b1, 2, 8'h5A);
    cfg_write(1'b1, 7, 8'h3C);
    cfg_write(1'b0, 3*NREGS + 4, 8'hE1);
    run_seq(3, 0, 0, 1'b0, 1'b0, "R12 reloaded tables");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule